// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the single-clock front end and storage of a flow-through synchronous static RAM. Every rising edge captures the address, the three chip enables, two burst-start strobes (one meant for a processor, one for a cache controller), the advance input, the write controls, the burst-order select and the write data. The registered controls are then decoded into one of five cycle kinds: idle, deselect, burst start, burst continue or burst suspend. Each cycle is also classed as a read or a write.

Storage is held as byte lanes. Each lane is eight data bits plus an optional parity bit, which is stored and returned like the other bits. A read is flow-through. The data for the registered address appears combinationally in the same cycle. It is driven only while the asynchronous output enable is high. A write is committed at the clock edge that closes its cycle, so a read in the next cycle already sees the new data.

A small burst sequencer produces the address for continue and suspend cycles. It wraps the low two address bits either in linear order or in interleaved (XOR) order. The pad-level tri-state lies outside the block: `rdrive_o` low means the data bus is high-Z.

Top module: `sbsram_ctrl`

## Requirements
- R1: After synchronous reset, `rdrive_o` is 0 and `rdata_o` is all zeros. The controller is deselected until a burst starts.
- R2: A processor-strobe cycle with the primary enable high and both secondary enables valid starts a burst at the external address as a read. The write inputs are ignored and no lane is written.
- R3: A controller-strobe cycle, with the processor strobe low and all enables valid, starts a burst at the external address. It is a write when `gw_i` is high, or when `bw_i` is high with at least one lane bit set. Otherwise it is a read. Written data is visible to a read in the next cycle.
- R4: With `gw_i` high, every lane is written, whatever `bw_i` and `lane_wr_i` hold.
- R5: With `gw_i` low and `bw_i` high, only lanes whose `lane_wr_i[i]` bit is 1 are written. Lane i occupies data bits i*9 to i*9+8. With `bw_i` high and no lane bit set, the cycle is a read.
- R6: With the primary enable low, a controller-strobe cycle deselects and the bus is not driven. A processor strobe is ignored, so the cycle behaves as a continue or a suspend.
- R7: The secondary enables (`sel_hi_i` must be 1 and `sel_lo_n_i` must be 0) are checked only in cycles where a strobe is high. A failing secondary deselects such a cycle. In continue cycles the secondary enables have no effect.
- R8: With no strobe and `adv_i` high, the burst advances. With `burst_ilv_i`=0 the low two address bits step +1 modulo 4 from the start address, for example 2,3,0,1,2. The upper bits are held.
- R9: With `burst_ilv_i`=1, the k-th address after the start has low bits equal to start XOR k, for example 1,0,3,2.
- R10: With no strobe and `adv_i` low, the burst is suspended and the current address repeats. Continue and suspend cycles may read or write under the same write-control rules.
- R11: A read cycle drives `rdrive_o`=1 and `rdata_o` with the addressed word in the same cycle, provided `oe_i` is high. `oe_i` low forces `rdrive_o`=0 and `rdata_o`=0 without a clock edge. Write cycles never drive.
- R12: In each lane the top bit (bit i*9+8) is a parity bit that is stored and read back unchanged.
- R13: After a deselect and before the next burst start, continue and suspend cycles neither write the array nor drive the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | External word address |
| ce_i | input | 1 | Primary chip enable, active high |
| sel_hi_i | input | 1 | Secondary enable, active high, checked with a strobe |
| sel_lo_n_i | input | 1 | Secondary enable, active low, checked with a strobe |
| start_cpu_i | input | 1 | Processor burst-start strobe (start is always a read) |
| start_ctl_i | input | 1 | Controller burst-start strobe |
| adv_i | input | 1 | Burst advance (1) or suspend (0) |
| gw_i | input | 1 | Global write: all lanes |
| bw_i | input | 1 | Byte-write enable, qualifies `lane_wr_i` |
| lane_wr_i | input | LANES | Per-lane write select |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_i | input | 1 | Asynchronous output enable |
| wdata_i | input | LANES*(8+PARITY) | Write data, captured with the cycle |
| rdata_o | output | LANES*(8+PARITY) | Read data, zero when not driven |
| rdrive_o | output | 1 | Bus drive enable; 0 means high-Z |

## Verification
The bench targets the following cases and the failure each one exposes:
- A processor strobe presented with a global write asserted. A design that lets write controls through on that start would corrupt the word.
- A byte-write enable with an empty lane mask. Treating this as a write of nothing, rather than as a read, leaves the bus undriven.
- Burst wrap at the end of the four-beat group in both orders. A wrong carry or a wrong order reads neighbouring words.
- A processor strobe under a low primary enable, and secondary enables that fail only during continue cycles. A design that samples these signals at the wrong time deselects or restarts a live burst.
- A write attempted after a deselect. This is checked by reading the word back later, which reveals continue cycles that still write while deselected.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DESEL = 3'd1,
    OP_START = 3'd2,
    OP_CONT  = 3'd3,
    OP_SUSP  = 3'd4
  } cyc_op_e;

  typedef struct packed {
    logic ce;
    logic sel_hi;
    logic sel_lo_n;
    logic start_cpu;
    logic start_ctl;
    logic adv;
    logic gw;
    logic bw;
  } ctl_t;

  // low two address bits of beat cnt within a four-beat group
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/sbsram_in_reg.sv
module sbsram_in_reg
  import sbsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl_d,
  input  logic [AW-1:0]    addr_d,
  input  logic [LANES-1:0] lane_d,
  input  logic             ilv_d,
  input  logic [DW-1:0]    wdata_d,
  output ctl_t             ctl_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] lane_q,
  output logic             ilv_q,
  output logic [DW-1:0]    wdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      lane_q  <= '0;
      ilv_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      addr_q  <= addr_d;
      lane_q  <= lane_d;
      ilv_q   <= ilv_d;
      wdata_q <= wdata_d;
    end
  end

endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [LANES-1:0] lane,
  input  logic             active,
  output cyc_op_e          op,
  output logic             rd_cycle,
  output logic [LANES-1:0] lane_we
);

  logic             sec_ok;
  logic             wr_req;
  logic             is_wr;
  logic [LANES-1:0] lane_sel;

  assign sec_ok   = ctl.sel_hi & ~ctl.sel_lo_n;
  assign wr_req   = ctl.gw | (ctl.bw & (|lane));
  assign lane_sel = ctl.gw ? {LANES{1'b1}} : (ctl.bw ? lane : '0);

  always_comb begin
    op    = OP_IDLE;
    is_wr = 1'b0;
    if (ctl.start_cpu && ctl.ce) begin
      op = sec_ok ? OP_START : OP_DESEL;
    end else if (ctl.start_ctl) begin
      op    = (ctl.ce && sec_ok) ? OP_START : OP_DESEL;
      is_wr = wr_req;
    end else if (active) begin
      op    = ctl.adv ? OP_CONT : OP_SUSP;
      is_wr = wr_req;
    end
  end

  logic live;
  assign live     = (op == OP_START) || (op == OP_CONT) || (op == OP_SUSP);
  assign lane_we  = (live && is_wr) ? lane_sel : '0;
  assign rd_cycle = live && !is_wr;

  // R2: processor-strobe start never writes
  assert_cpu_start_read_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.start_cpu && ctl.ce) |-> (lane_we == '0));

  // R13: idle and deselect cycles never write
  assert_quiet_no_write_R13: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE || op == OP_DESEL) |-> (lane_we == '0));

endmodule

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_op_e       op,
  input  logic [AW-1:0] ext_addr,
  input  logic          ilv,
  output logic [AW-1:0] cyc_addr,
  output logic          active
);

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nx;

  assign cnt_nx = cnt + 2'd1;

  always_comb begin
    unique case (op)
      OP_START: cyc_addr = ext_addr;
      OP_CONT:  cyc_addr = {base[AW-1:2], burst_lo(base[1:0], cnt_nx, ilv)};
      default:  cyc_addr = {base[AW-1:2], burst_lo(base[1:0], cnt, ilv)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      unique case (op)
        OP_START: begin
          base   <= ext_addr;
          cnt    <= '0;
          active <= 1'b1;
        end
        OP_CONT:  cnt    <= cnt_nx;
        OP_DESEL: active <= 1'b0;
        default:  ;
      endcase
    end
  end

  // R8: linear continue steps the low bits by one and holds the rest
  assert_linear_step_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CONT && !ilv && !$past(ilv)) |->
      (cyc_addr[1:0] == 2'($past(cyc_addr[1:0]) + 2'd1) &&
       cyc_addr[AW-1:2] == $past(cyc_addr[AW-1:2])));

  // R10: suspend repeats the previous cycle's address
  assert_suspend_repeat_R10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUSP && ilv == $past(ilv)) |-> (cyc_addr == $past(cyc_addr)));

endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LW
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = mem[addr];
  end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int PARITY = 1,
  localparam int LW    = 8 + PARITY,
  localparam int DW    = LANES * LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_i,
  input  logic             ce_i,
  input  logic             sel_hi_i,
  input  logic             sel_lo_n_i,
  input  logic             start_cpu_i,
  input  logic             start_ctl_i,
  input  logic             adv_i,
  input  logic             gw_i,
  input  logic             bw_i,
  input  logic [LANES-1:0] lane_wr_i,
  input  logic             burst_ilv_i,
  input  logic             oe_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdrive_o
);

  ctl_t             ctl_d, ctl_q;
  logic [AW-1:0]    addr_q, cyc_addr;
  logic [LANES-1:0] lane_q, lane_we;
  logic             ilv_q, active, rd_cycle;
  logic [DW-1:0]    wdata_q, arr_rdata;
  cyc_op_e          op;

  assign ctl_d = '{ce: ce_i, sel_hi: sel_hi_i, sel_lo_n: sel_lo_n_i,
                   start_cpu: start_cpu_i, start_ctl: start_ctl_i,
                   adv: adv_i, gw: gw_i, bw: bw_i};

  sbsram_in_reg #(.AW(AW), .LANES(LANES), .DW(DW)) u_in_reg (
    .clk(clk), .rst(rst),
    .ctl_d(ctl_d), .addr_d(addr_i), .lane_d(lane_wr_i), .ilv_d(burst_ilv_i),
    .wdata_d(wdata_i),
    .ctl_q(ctl_q), .addr_q(addr_q), .lane_q(lane_q), .ilv_q(ilv_q),
    .wdata_q(wdata_q)
  );

  sbsram_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst(rst),
    .ctl(ctl_q), .lane(lane_q), .active(active),
    .op(op), .rd_cycle(rd_cycle), .lane_we(lane_we)
  );

  sbsram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst),
    .op(op), .ext_addr(addr_q), .ilv(ilv_q),
    .cyc_addr(cyc_addr), .active(active)
  );

  sbsram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .we(lane_we), .addr(cyc_addr), .wdata(wdata_q),
    .rdata(arr_rdata)
  );

  assign rdrive_o = oe_i & rd_cycle;
  assign rdata_o  = rdrive_o ? arr_rdata : '0;

  // R6: a deselect cycle never drives the bus
  assert_desel_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |-> !rdrive_o);

  // R11: a write cycle never drives the bus
  assert_write_no_drive_R11: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> !rdrive_o);

endmodule

// File: tb/sbsram_ctrl_tb.sv
module sbsram_ctrl_tb;

  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_i;
  logic ce_i, sel_hi_i, sel_lo_n_i, start_cpu_i, start_ctl_i, adv_i;
  logic gw_i, bw_i, burst_ilv_i, oe_i;
  logic [LANES-1:0] lane_wr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic rdrive_o;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  sbsram_ctrl #(.AW(AW), .LANES(LANES), .PARITY(1)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .ce_i(ce_i), .sel_hi_i(sel_hi_i),
    .sel_lo_n_i(sel_lo_n_i), .start_cpu_i(start_cpu_i),
    .start_ctl_i(start_ctl_i), .adv_i(adv_i), .gw_i(gw_i), .bw_i(bw_i),
    .lane_wr_i(lane_wr_i), .burst_ilv_i(burst_ilv_i), .oe_i(oe_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rdrive_o(rdrive_o)
  );

  function automatic logic [DW-1:0] vpat(input int a);
    logic [8:0] b = a[8:0];
    return {b + 9'd3, b + 9'h102, b + 9'd1, b};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    addr_i = '0; ce_i = 1'b1; sel_hi_i = 1'b1; sel_lo_n_i = 1'b0;
    start_cpu_i = 1'b0; start_ctl_i = 1'b0; adv_i = 1'b0;
    gw_i = 1'b0; bw_i = 1'b0; lane_wr_i = '0; oe_i = 1'b1; wdata_i = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl_cycle(input int a, input logic gw, input logic bw,
                           input logic [LANES-1:0] ln, input logic [DW-1:0] d);
    quiet();
    burst_ilv_i = burst_ilv_i;
    addr_i = AW'(a); start_ctl_i = 1'b1; gw_i = gw; bw_i = bw;
    lane_wr_i = ln; wdata_i = d;
    step();
  endtask

  task automatic adv_cycle(input logic adv);
    quiet();
    adv_i = adv;
    step();
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 drive after reset", DW'(rdrive_o), DW'(0));
    chk("R1 data after reset", rdata_o, '0);
    adv_cycle(1'b1);
    chk("R1 idle continue does not drive", DW'(rdrive_o), DW'(0));
  endtask

  task automatic t_global();
    logic [DW-1:0] d1 = {9'h1A5, 9'h03C, 9'h1FF, 9'h081};
    ctl_cycle(8, 1'b1, 1'b1, 4'b0000, d1);
    chk("R11 write cycle not driven", DW'(rdrive_o), DW'(0));
    ctl_cycle(8, 1'b0, 1'b0, 4'b0000, '1);
    chk("R3 read start drives", DW'(rdrive_o), DW'(1));
    chk("R4 global write all lanes", rdata_o, d1);
    chk("R12 parity bits returned",
        DW'({rdata_o[35], rdata_o[26], rdata_o[17], rdata_o[8]}), DW'(4'b1010));
  endtask

  task automatic t_bytes();
    logic [DW-1:0] exp = {9'h1A5, 9'h122, 9'h1FF, 9'h144};
    ctl_cycle(8, 1'b0, 1'b1, 4'b0101, {9'h111, 9'h122, 9'h133, 9'h144});
    ctl_cycle(8, 1'b0, 1'b0, 4'b0000, '0);
    chk("R5 only selected lanes written", rdata_o, exp);
    ctl_cycle(8, 1'b0, 1'b1, 4'b0000, '1);
    chk("R5 empty lane mask is a read (drive)", DW'(rdrive_o), DW'(1));
    chk("R5 empty lane mask is a read (data)", rdata_o, exp);
    ctl_cycle(8, 1'b0, 1'b0, 4'b0000, '0);
    chk("R5 empty lane mask left word intact", rdata_o, exp);
  endtask

  task automatic t_cpu();
    logic [DW-1:0] exp = {9'h1A5, 9'h122, 9'h1FF, 9'h144};
    quiet();
    addr_i = AW'(8); start_cpu_i = 1'b1; gw_i = 1'b1; wdata_i = '0;
    step();
    chk("R2 cpu start reads (drive)", DW'(rdrive_o), DW'(1));
    chk("R2 cpu start reads (data)", rdata_o, exp);
    ctl_cycle(8, 1'b0, 1'b0, 4'b0000, '0);
    chk("R2 cpu start wrote nothing", rdata_o, exp);
  endtask

  task automatic t_linear();
    for (int a = 16; a < 21; a++) ctl_cycle(a, 1'b1, 1'b0, 4'b0000, vpat(a));
    burst_ilv_i = 1'b0;
    ctl_cycle(18, 1'b0, 1'b0, 4'b0000, '0);
    chk("R8 linear start", rdata_o, vpat(18));
    adv_cycle(1'b1); chk("R8 linear beat 1", rdata_o, vpat(19));
    adv_cycle(1'b1); chk("R8 linear wrap beat 2", rdata_o, vpat(16));
    adv_cycle(1'b1); chk("R8 linear beat 3", rdata_o, vpat(17));
    adv_cycle(1'b1); chk("R8 linear back to start", rdata_o, vpat(18));
  endtask

  task automatic t_interleave();
    burst_ilv_i = 1'b1;
    ctl_cycle(17, 1'b0, 1'b0, 4'b0000, '0);
    chk("R9 interleave start", rdata_o, vpat(17));
    adv_cycle(1'b1); chk("R9 interleave beat 1", rdata_o, vpat(16));
    adv_cycle(1'b1); chk("R9 interleave beat 2", rdata_o, vpat(19));
    adv_cycle(1'b1); chk("R9 interleave beat 3", rdata_o, vpat(18));
    burst_ilv_i = 1'b0;
    adv_cycle(1'b0);
  endtask

  task automatic t_suspend();
    ctl_cycle(16, 1'b0, 1'b0, 4'b0000, '0);
    chk("R10 start", rdata_o, vpat(16));
    adv_cycle(1'b0); chk("R10 suspend repeats", rdata_o, vpat(16));
    adv_cycle(1'b1); chk("R10 advance after suspend", rdata_o, vpat(17));
    adv_cycle(1'b0); chk("R10 second suspend", rdata_o, vpat(17));
  endtask

  task automatic t_oe();
    ctl_cycle(19, 1'b0, 1'b0, 4'b0000, '0);
    chk("R11 flow-through same cycle", rdata_o, vpat(19));
    oe_i = 1'b0; #1;
    chk("R11 oe low releases bus", DW'(rdrive_o), DW'(0));
    chk("R11 oe low zero data", rdata_o, '0);
    oe_i = 1'b1; #1;
    chk("R11 oe high restores data", rdata_o, vpat(19));
  endtask

  task automatic t_desel();
    quiet();
    addr_i = AW'(20); start_ctl_i = 1'b1; ce_i = 1'b0;
    step();
    chk("R6 primary off deselects", DW'(rdrive_o), DW'(0));
    quiet(); gw_i = 1'b1; adv_i = 1'b0; wdata_i = '0; step();
    chk("R13 suspend after deselect silent", DW'(rdrive_o), DW'(0));
    quiet(); gw_i = 1'b1; adv_i = 1'b1; wdata_i = '0; step();
    chk("R13 continue after deselect silent", DW'(rdrive_o), DW'(0));
    ctl_cycle(20, 1'b0, 1'b0, 4'b0000, '0);
    chk("R13 no write after deselect", rdata_o, vpat(20));
    ctl_cycle(16, 1'b0, 1'b0, 4'b0000, '0);
    quiet(); ce_i = 1'b0; start_cpu_i = 1'b1; addr_i = AW'(19); adv_i = 1'b1;
    step();
    chk("R6 cpu strobe ignored, burst continues", rdata_o, vpat(17));
  endtask

  task automatic t_secondary();
    quiet(); addr_i = AW'(18); start_ctl_i = 1'b1; sel_hi_i = 1'b0; step();
    chk("R7 sel_hi low deselects", DW'(rdrive_o), DW'(0));
    quiet(); addr_i = AW'(18); start_ctl_i = 1'b1; sel_lo_n_i = 1'b1; step();
    chk("R7 sel_lo_n high deselects", DW'(rdrive_o), DW'(0));
    ctl_cycle(18, 1'b0, 1'b0, 4'b0000, '0);
    chk("R7 valid start", rdata_o, vpat(18));
    quiet(); adv_i = 1'b1; sel_hi_i = 1'b0; sel_lo_n_i = 1'b1; step();
    chk("R7 secondaries ignored on continue", rdata_o, vpat(19));
  endtask

  initial begin
    quiet();
    burst_ilv_i = 1'b0;
    t_reset();
    t_global();
    t_bytes();
    t_cpu();
    t_linear();
    t_interleave();
    t_suspend();
    t_oe();
    t_desel();
    t_secondary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule